// File: doc/BRIEF.md
# Dual Reference Monitor and Selector

This block watches two pulse references, each nominally 8 kHz, on a fast local clock. It tells a downstream phase-locked loop which reference to follow, or tells it to hold its frequency in free-run. Only rising edges of each reference matter, so any duty cycle is accepted. For each input, a counter of local clock cycles restarts on every rising edge. When no edge has arrived for one and a half nominal periods, that input is declared lost.

A select pin, a force-free-run pin and a reset pin combine with the two loss flags to give three results. The first is a registered two-bit choice code. The second is a free-run status flag and the third is an alarm flag. The alarm is raised when the chosen reference is lost. It is also raised by an external loss-of-lock level, but that term is hidden for a qualification window after every change of the select pin. An active-low enable floats the status and alarm pins.

Top module: `refsel_monitor`

## Requirements
- R1: While `rst` is 1, from the first clock edge on, `choice` is 00, `hold_stat` is 1 and `alarm` is 1.
- R2: Only rising edges count. An input with rising edges at the nominal period is active at any high time from 1 cycle to one period less 1. An input held at a constant level, high or low, becomes lost.
- R3: An input is flagged lost more than one and fewer than two nominal periods (`PERIOD_CYC` local cycles each) after its last rising edge.
- R4: When both inputs are lost, `choice` is 00, `hold_stat` is 1 and `alarm` is 1, whatever `sel_b` is.
- R5: When `force_hold` is 1, `choice` is 00, `hold_stat` is 1 and `alarm` is 1, whatever the inputs are doing.
- R6: When the selected input is lost and the other is active, `choice` is 11 (unstable), `hold_stat` is 0 and `alarm` is 1. The choice never moves to the other input by itself.
- R7: When the selected input is active and free-run is not forced, `choice` is 01 for A (`sel_b`=0) or 10 for B (`sel_b`=1), and `hold_stat` is 0. Outside the blanking window, `alarm` equals `lol_in`. The state of the other input has no effect.
- R8: Count the rising clock edges that follow a change of `sel_b`. On edges 1 to `BLANK_CYC`+1, `lol_in` is masked from `alarm`. From edge `BLANK_CYC`+2 on, it reaches `alarm`.
- R9: Loss of the selected input raises `alarm` even inside the blanking window.
- R10: While `oe_n` is 1, `hold_stat` and `alarm` are high impedance. `choice` stays driven.
- R11: `choice`, `hold_stat` and `alarm` are registered. A change of `force_hold`, `sel_b` or `lol_in` shows at the first rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a | input | 1 | Reference pulse input A |
| ref_b | input | 1 | Reference pulse input B |
| sel_b | input | 1 | Reference select: 0 picks A, 1 picks B |
| force_hold | input | 1 | Forces free-run when 1 |
| lol_in | input | 1 | Loss-of-lock level from the loop |
| oe_n | input | 1 | Active-low enable of the status pins |
| choice | output | 2 | 00 free-run, 01 A, 10 B, 11 unstable |
| hold_stat | output | 1 | Free-run status, tri-state |
| alarm | output | 1 | Loss of reference or lock, tri-state |

## Verification
A change of the select, force or loss-of-lock pin is due one clock edge after it is applied. The bench samples at the falling edge just before that edge and just after it. The loss-of-lock term is due on exactly the second edge past the blanking count, and the bench counts edges to sample on both sides of it. Reference loss and recovery take up to two periods plus the synchronizer delay. So the random phase waits three periods plus the blanking window before it compares against the bench's model, and the loss-window test samples at exactly one and two periods after the last rising edge. The tri-state check samples on pulled-up nets in the same cycle the enable changes.

// File: rtl/refsel_monitor.sv
module refsel_monitor #(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 1000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       sel_b,
  input  logic       force_hold,
  input  logic       lol_in,
  input  logic       oe_n,
  output logic [1:0] choice,
  output logic       hold_stat,
  output logic       alarm
);
  localparam int LOSS_CYC = PERIOD_CYC + PERIOD_CYC / 2;
  localparam int LW = $clog2(LOSS_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [1:0] CH_FREE = 2'b00;
  localparam logic [1:0] CH_A    = 2'b01;
  localparam logic [1:0] CH_B    = 2'b10;
  localparam logic [1:0] CH_UNST = 2'b11;

  logic [1:0] ref_in;
  logic [1:0] lost;
  assign ref_in = {ref_b, ref_a};

  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic [2:0]    sync;
    logic [LW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        sync <= '0;
        cnt  <= LW'(LOSS_CYC);
      end else begin
        sync <= {sync[1:0], ref_in[g]};
        if (sync[1] && !sync[2])
          cnt <= '0;
        else if (cnt != LW'(LOSS_CYC))
          cnt <= cnt + 1'b1;
      end
    end
    assign lost[g] = (cnt == LW'(LOSS_CYC));
  end

  logic          sel_prev;
  logic [BW-1:0] blank_cnt;
  logic          blanked;
  assign blanked = (sel_b ^ sel_prev) | (blank_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev  <= sel_b;
      blank_cnt <= '0;
    end else begin
      sel_prev <= sel_b;
      if (sel_b ^ sel_prev)
        blank_cnt <= BW'(BLANK_CYC);
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;
    end
  end

  logic       sel_lost;
  logic [1:0] nxt_choice;
  logic       nxt_hold, nxt_alarm;
  assign sel_lost = sel_b ? lost[1] : lost[0];

  always_comb begin
    if (force_hold || (&lost)) begin
      nxt_choice = CH_FREE;
      nxt_hold   = 1'b1;
      nxt_alarm  = 1'b1;
    end else if (sel_lost) begin
      nxt_choice = CH_UNST;
      nxt_hold   = 1'b0;
      nxt_alarm  = 1'b1;
    end else begin
      nxt_choice = sel_b ? CH_B : CH_A;
      nxt_hold   = 1'b0;
      nxt_alarm  = lol_in & ~blanked;
    end
  end

  logic hold_q, alarm_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      choice  <= CH_FREE;
      hold_q  <= 1'b1;
      alarm_q <= 1'b1;
    end else begin
      choice  <= nxt_choice;
      hold_q  <= nxt_hold;
      alarm_q <= nxt_alarm;
    end
  end

  assign hold_stat = oe_n ? 1'bz : hold_q;
  assign alarm     = oe_n ? 1'bz : alarm_q;
endmodule

// File: rtl/refsel_monitor_chk.sv
module refsel_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_b,
  input logic       force_hold,
  input logic       lol_in,
  input logic [1:0] lost,
  input logic       blank_busy,
  input logic [1:0] choice,
  input logic       hold_q,
  input logic       alarm_q
);
  a_r5_force_free: assert property (@(posedge clk) disable iff (rst)
    force_hold |=> (choice == 2'b00 && hold_q && alarm_q));

  a_r4_both_lost: assert property (@(posedge clk) disable iff (rst)
    (&lost) |=> (choice == 2'b00 && hold_q && alarm_q));

  a_r6_unstable: assert property (@(posedge clk) disable iff (rst)
    (!force_hold && !(&lost) && (sel_b ? lost[1] : lost[0]))
      |=> (choice == 2'b11 && alarm_q && !hold_q));

  a_r7_locked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!force_hold && !lol_in && !(sel_b ? lost[1] : lost[0]))
      |=> (!alarm_q && !hold_q));

  a_r8_blank_mask: assert property (@(posedge clk) disable iff (rst)
    (blank_busy && !force_hold && lost == 2'b00) |=> !alarm_q);
endmodule

bind refsel_monitor refsel_monitor_chk u_chk (
  .clk(clk), .rst(rst), .sel_b(sel_b), .force_hold(force_hold),
  .lol_in(lol_in), .lost(lost), .blank_busy(blank_cnt != '0),
  .choice(choice), .hold_q(hold_q), .alarm_q(alarm_q)
);

// File: tb/sim_refsel_monitor.sv
module sim_refsel_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 40;
  localparam int BL = 200;

  logic clk = 0, rst = 1, ref_a = 0, ref_b = 0;
  logic sel_b = 0, force_hold = 0, lol_in = 0, oe_n = 0;
  logic [1:0] choice;
  wire hold_w, alarm_w;
  pullup (hold_w);
  pullup (alarm_w);

  refsel_monitor #(.PERIOD_CYC(P), .BLANK_CYC(BL)) u0 (
    .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b), .sel_b(sel_b),
    .force_hold(force_hold), .lol_in(lol_in), .oe_n(oe_n),
    .choice(choice), .hold_stat(hold_w), .alarm(alarm_w));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit a_en = 1, b_en = 1;
  int duty_a = P/2, duty_b = P/2, pa = 0, pb = 0;

  initial forever begin
    @(negedge clk);
    if (a_en) begin pa = (pa + 1) % P; ref_a = (pa < duty_a); end
    if (b_en) begin pb = (pb + 1) % (P + 2); ref_b = (pb < duty_b); end
  end

  function automatic logic [3:0] model(bit a_on, bit b_on, bit sel, bit frc, bit lol);
    if (frc || (!a_on && !b_on)) return 4'b0011;
    if (sel ? !b_on : !a_on)     return 4'b1101;
    return {sel ? 2'b10 : 2'b01, 1'b0, lol};
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {choice, hold_w, alarm_w};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cycles(5);
    check("R1 reset", 4'b0011);
    rst = 0;
    cycles(3*P + 5);
    check("R7 locked A", 4'b0100);

    oe_n = 1; #1;
    check("R10 disabled pins float", 4'b0111);
    @(negedge clk); oe_n = 0; #1;
    check("R10 re-enabled", 4'b0100);

    @(negedge clk); force_hold = 1; #1;
    check("R11 not before edge", 4'b0100);
    @(negedge clk);
    check("R5 R11 force after one edge", 4'b0011);
    force_hold = 0;
    cycles(2);
    check("R5 release", 4'b0100);

    @(posedge ref_a); a_en = 0;
    cycles(P);
    check("R3 not yet lost at one period", 4'b0100);
    cycles(P);
    check("R3 R6 R2 lost held high, unstable", 4'b1101);
    a_en = 1;
    cycles(3*P);
    check("R2 recovered", 4'b0100);

    lol_in = 1;
    cycles(3);
    check("R7 lol reaches alarm", 4'b0101);
    sel_b = 1;
    repeat (BL + 1) @(posedge clk);
    @(negedge clk);
    check("R8 still masked", 4'b1000);
    @(posedge clk); @(negedge clk);
    check("R8 unmasked", 4'b1001);

    sel_b = 0; a_en = 0;
    cycles(2*P + 5);
    check("R9 loss shows inside blank", 4'b1101);
    a_en = 1; lol_in = 0;
    cycles(3*P + BL);
    check("R6 back to locked A", 4'b0100);

    a_en = 0; b_en = 0; sel_b = 1;
    cycles(2*P + 5);
    check("R4 both lost sel=1", 4'b0011);
    sel_b = 0; cycles(2);
    check("R4 both lost sel=0", 4'b0011);

    for (int i = 0; i < 30; i++) begin
      bit ra, rb, rs, rf, rl;
      ra = 1'($urandom); rb = 1'($urandom); rs = 1'($urandom);
      rf = ($urandom % 5) == 0; rl = 1'($urandom);
      duty_a = 1 + int'($urandom % (P - 1));
      duty_b = 1 + int'($urandom % (P + 1));
      a_en = ra; b_en = rb; sel_b = rs; force_hold = rf; lol_in = rl;
      cycles(3*P + BL + 10);
      check("R2 R4 R5 R6 R7 random", model(ra, rb, rs, rf, rl));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule